// File: doc/BRIEF.md
# Comparator Trip Filter with Ramp Delay

This block is the digital back end of one analog comparator channel. It holds a ramp-delay counter: on each rising edge of a synchronization input, the counter is reloaded from a shadow delay value. It then counts down once per clock until it reaches zero and stays there. The ramp reference logic downstream uses that count as its start delay.

Alongside the counter sit two majority-vote filters, one for the high comparator output and one for the low comparator output. Each filter has its own sample prescaler, its own window length N (1 to 32) and its own threshold T. Each filter shifts its raw input into a sample window on a periodic strobe. Its output is set when enough of the newest N samples agree. Each filter output is presented as a status bit.

The delay counter is a two-state machine. In `RD_IDLE` the count is zero and held. In `RD_COUNT` the count is non-zero and falling. The transitions are:
- A sync rise loads the shadow value and moves to `RD_COUNT`, or to `RD_IDLE` when the shadow value is 0.
- The count reaching zero moves from `RD_COUNT` to `RD_IDLE`.

Each filter output is a two-state machine with states `FO_LOW` and `FO_HIGH`. On a sample strobe:
- A ones majority moves it to `FO_HIGH`.
- A zeros majority moves it to `FO_LOW`.
- Otherwise it stays in its current state.

Top module: `cmp_trip_backend`

## Requirements
- R1: While `rst` is high at a clock edge, `dly_count` becomes 0, both status bits become 0, every sample window is cleared to all zeros and both prescaler phases restart.
- R2: At a clock edge where `sync_in` is 1 and was 0 at the previous edge (or that edge was a reset edge), `dly_count` takes the value of `dly_shadow`.
- R3: At an edge with no sync rise, a non-zero `dly_count` falls by exactly one. A zero `dly_count` stays zero. Holding `sync_in` high causes no further reload.
- R4: A shadow value of 0 gives a count of 0 at the load edge. The full-scale shadow value (all ones) loads unchanged and then counts down from there.
- R5: A sync rise while the count is still non-zero restarts the count from the current shadow value.
- R6: With prescale value P, a filter samples its raw input on the (P+1)-th clock edge after reset release and then on every (P+1)-th edge. Its status changes only at those edges.
- R7: At a sample edge, the window's newest N samples are counted, including the sample just taken. The status goes to 1 if at least T of them are 1, goes to 0 if at least T are 0, and otherwise keeps its value. T must be at least 1 and greater than N/2.
- R8: The high and low filters use their own N, T, prescale and raw input. Neither filter affects the other's status.
- R9: Window lengths from 1 to 32 are legal. With N=1 and T=1, the status equals the sample taken at the most recent strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Synchronization pulse; a rising edge reloads the delay |
| dly_shadow | input | DLY_W | Delay value loaded on sync rise |
| dly_count | output | DLY_W | Active ramp-delay count |
| hi_raw | input | 1 | Raw high comparator output |
| hi_win_len | input | CNT_W | High filter window length N |
| hi_thresh | input | CNT_W | High filter threshold T |
| hi_prescale | input | PRE_W | High filter prescale P |
| hi_status | output | 1 | Filtered high comparator state |
| lo_raw | input | 1 | Raw low comparator output |
| lo_win_len | input | CNT_W | Low filter window length N |
| lo_thresh | input | CNT_W | Low filter threshold T |
| lo_prescale | input | PRE_W | Low filter prescale P |
| lo_status | output | 1 | Filtered low comparator state |

## Verification
A wrong delay state appears on `dly_count` at the very next edge. A count that skips a value, wraps below zero or misses a reload differs from the expected count within one cycle.

A damaged sample window or a wrong prescaler phase stays hidden until the next strobe. It then shows as a status bit that flips one sample early or late, or that fails to flip. The bench therefore compares both status bits and the count against a reference model on every cycle, across many random window, threshold and prescale settings.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;
    typedef enum logic {RD_IDLE, RD_COUNT} rd_state_e;
    typedef enum logic {FO_LOW, FO_HIGH} fo_state_e;
endpackage

// File: rtl/cmpf_ramp_delay.sv
module cmpf_ramp_delay
    import cmpf_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_in,
    input  logic [DLY_W-1:0] shadow,
    output logic [DLY_W-1:0] count
);
    rd_state_e        state_q, state_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;
    logic             sync_q;
    logic             rise;

    assign rise = sync_in & ~sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RD_IDLE;
            cnt_q   <= '0;
            sync_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sync_q  <= sync_in;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (rise) begin
            cnt_d   = shadow;
            state_d = (shadow == '0) ? RD_IDLE : RD_COUNT;
        end else begin
            unique case (state_q)
                RD_IDLE:  cnt_d = cnt_q;
                RD_COUNT: begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_q == DLY_W'(1)) state_d = RD_IDLE;
                end
            endcase
        end
    end

    assign count = cnt_q;

    // R2: a sync rise loads the shadow value
    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        rise |=> (count == $past(shadow)));
    // R3: count falls by one while non-zero
    a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
        (!rise && count != '0) |=> (count == $past(count) - 1'b1));
    // R3: zero holds without a reload
    a_r3_hold_zero: assert property (@(posedge clk) disable iff (rst)
        (!rise && count == '0) |=> (count == '0));
endmodule

// File: rtl/cmpf_prescaler.sv
module cmpf_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] prescale,
    output logic             strobe
);
    logic [PRE_W-1:0] pc_q;

    assign strobe = (pc_q >= prescale);

    always_ff @(posedge clk) begin
        if (rst)         pc_q <= '0;
        else if (strobe) pc_q <= '0;
        else             pc_q <= pc_q + 1'b1;
    end

    // R6: a strobe is never followed directly by another unless P is 0
    a_r6_strobe_gap: assert property (@(posedge clk) disable iff (rst)
        (strobe && prescale != '0) |=> (!strobe || prescale == '0));
endmodule

// File: rtl/cmpf_majority_filter.sv
module cmpf_majority_filter
    import cmpf_pkg::*;
#(
    parameter int WIN_MAX = 32,
    parameter int CNT_W   = $clog2(WIN_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             raw,
    input  logic [CNT_W-1:0] win_len,
    input  logic [CNT_W-1:0] thresh,
    output logic             status
);
    fo_state_e          state_q, state_d;
    logic [WIN_MAX-1:0] win_q, win_next, mask;
    logic [CNT_W-1:0]   ones, zeros;

    assign win_next = {win_q[WIN_MAX-2:0], raw};

    always_comb begin
        ones = '0;
        for (int i = 0; i < WIN_MAX; i++) begin
            mask[i] = (i < int'(win_len));
            ones    = ones + CNT_W'(win_next[i] & mask[i]);
        end
        zeros = win_len - ones;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FO_LOW;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            if (strobe) win_q <= win_next;
        end
    end

    always_comb begin
        state_d = state_q;
        if (strobe) begin
            unique case (state_q)
                FO_LOW:  if (ones >= thresh)  state_d = FO_HIGH;
                FO_HIGH: if (zeros >= thresh) state_d = FO_LOW;
            endcase
        end
    end

    always_comb status = (state_q == FO_HIGH);

    // R6: status moves only at a sample edge
    a_r6_change_on_strobe: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(status));
    // R9: a one-sample window follows its sample
    a_r9_single_follow: assert property (@(posedge clk) disable iff (rst)
        (strobe && win_len == CNT_W'(1) && thresh == CNT_W'(1)) |=> (status == $past(raw)));
endmodule

// File: rtl/cmp_trip_backend.sv
module cmp_trip_backend #(
    parameter int DLY_W   = 16,
    parameter int WIN_MAX = 32,
    parameter int PRE_W   = 8,
    localparam int CNT_W  = $clog2(WIN_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_in,
    input  logic [DLY_W-1:0] dly_shadow,
    output logic [DLY_W-1:0] dly_count,
    input  logic             hi_raw,
    input  logic [CNT_W-1:0] hi_win_len,
    input  logic [CNT_W-1:0] hi_thresh,
    input  logic [PRE_W-1:0] hi_prescale,
    output logic             hi_status,
    input  logic             lo_raw,
    input  logic [CNT_W-1:0] lo_win_len,
    input  logic [CNT_W-1:0] lo_thresh,
    input  logic [PRE_W-1:0] lo_prescale,
    output logic             lo_status
);
    localparam int NCH = 2;

    logic             raw_v    [NCH];
    logic [CNT_W-1:0] len_v    [NCH];
    logic [CNT_W-1:0] thr_v    [NCH];
    logic [PRE_W-1:0] pre_v    [NCH];
    logic             stb_v    [NCH];
    logic             status_v [NCH];

    assign raw_v[0] = hi_raw;      assign raw_v[1] = lo_raw;
    assign len_v[0] = hi_win_len;  assign len_v[1] = lo_win_len;
    assign thr_v[0] = hi_thresh;   assign thr_v[1] = lo_thresh;
    assign pre_v[0] = hi_prescale; assign pre_v[1] = lo_prescale;
    assign hi_status = status_v[0];
    assign lo_status = status_v[1];

    cmpf_ramp_delay #(.DLY_W(DLY_W)) u_delay (
        .clk(clk), .rst(rst), .sync_in(sync_in),
        .shadow(dly_shadow), .count(dly_count)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        cmpf_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk(clk), .rst(rst), .prescale(pre_v[ch]), .strobe(stb_v[ch])
        );
        cmpf_majority_filter #(.WIN_MAX(WIN_MAX), .CNT_W(CNT_W)) u_flt (
            .clk(clk), .rst(rst), .strobe(stb_v[ch]), .raw(raw_v[ch]),
            .win_len(len_v[ch]), .thresh(thr_v[ch]), .status(status_v[ch])
        );
    end

    // R1: the edge after a reset edge shows the cleared state
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (dly_count == '0 && !hi_status && !lo_status));
endmodule

// File: tb/cmp_trip_backend_test.sv
module cmp_trip_backend_test;
    localparam int DLY_W = 16;
    localparam int PRE_W = 8;
    localparam int CNT_W = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst = 1'b1, sync_in = 1'b0;
    logic [DLY_W-1:0] dly_shadow = '0;
    logic [DLY_W-1:0] dly_count;
    logic             raw [2];
    logic [CNT_W-1:0] wl [2], th [2];
    logic [PRE_W-1:0] pr [2];
    logic             hi_status, lo_status;

    int n_checks = 0, n_fail = 0;

    cmp_trip_backend uut (
        .clk(clk), .rst(rst), .sync_in(sync_in), .dly_shadow(dly_shadow),
        .dly_count(dly_count),
        .hi_raw(raw[0]), .hi_win_len(wl[0]), .hi_thresh(th[0]),
        .hi_prescale(pr[0]), .hi_status(hi_status),
        .lo_raw(raw[1]), .lo_win_len(wl[1]), .lo_thresh(th[1]),
        .lo_prescale(pr[1]), .lo_status(lo_status)
    );

    // reference model, updated from pre-edge input values
    logic [DLY_W-1:0] m_cnt = '0;
    logic             m_sync = 1'b0;
    logic [31:0]      m_win [2];
    logic             m_out [2];
    int               m_pc  [2];

    function automatic int ones_in(logic [31:0] w, int n);
        int c = 0;
        for (int i = 0; i < n; i++) c += int'(w[i]);
        return c;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = '0; m_sync = 1'b0;
            for (int c = 0; c < 2; c++) begin
                m_win[c] = '0; m_out[c] = 1'b0; m_pc[c] = 0;
            end
        end else begin
            if (sync_in && !m_sync) m_cnt = dly_shadow;
            else if (m_cnt != '0)   m_cnt = m_cnt - 1'b1;
            m_sync = sync_in;
            for (int c = 0; c < 2; c++) begin
                if (m_pc[c] == int'(pr[c])) begin
                    int k;
                    m_pc[c]  = 0;
                    m_win[c] = {m_win[c][30:0], raw[c]};
                    k = ones_in(m_win[c], int'(wl[c]));
                    if (k >= int'(th[c]))                      m_out[c] = 1'b1;
                    else if (int'(wl[c]) - k >= int'(th[c]))   m_out[c] = 1'b0;
                end else begin
                    m_pc[c]++;
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // wait for a falling edge and compare all outputs to the model
    task automatic step(string tag);
        @(negedge clk);
        chk({tag, " count"}, 32'(dly_count), 32'(m_cnt));
        chk({tag, " hi"}, 32'(hi_status), 32'(m_out[0]));
        chk({tag, " lo"}, 32'(lo_status), 32'(m_out[1]));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step("R1");
        rst = 1'b0;
    endtask

    initial begin
        logic lvl [2];
        raw[0] = 0; raw[1] = 0;
        wl[0] = 1; wl[1] = 1; th[0] = 1; th[1] = 1; pr[0] = 0; pr[1] = 0;
        void'($urandom(32'd1357));
        repeat (2) @(negedge clk);
        do_reset();
        chk("R1 count zero", 32'(dly_count), 0);
        chk("R1 hi zero", 32'(hi_status), 0);
        chk("R1 lo zero", 32'(lo_status), 0);

        // R2 R3: load 5 and count down to zero, then hold
        dly_shadow = 16'd5; sync_in = 1'b1;
        step("R2");
        chk("R2 load", 32'(dly_count), 5);
        for (int i = 4; i >= 0; i--) begin
            step("R3");
            chk("R3 down", 32'(dly_count), 32'(i));
        end
        repeat (3) step("R3");
        chk("R3 hold zero with sync high", 32'(dly_count), 0);
        // R5: restart mid-count
        sync_in = 1'b0; step("R5");
        dly_shadow = 16'd9; sync_in = 1'b1; step("R5");
        sync_in = 1'b0; step("R5"); step("R5");
        chk("R5 mid", 32'(dly_count), 7);
        dly_shadow = 16'd20; sync_in = 1'b1; step("R5");
        chk("R5 restart", 32'(dly_count), 20);
        // R4: zero and full-scale loads
        sync_in = 1'b0; dly_shadow = 16'd0; step("R4");
        sync_in = 1'b1; step("R4");
        chk("R4 zero load", 32'(dly_count), 0);
        step("R4");
        chk("R4 zero stays", 32'(dly_count), 0);
        sync_in = 1'b0; dly_shadow = 16'hFFFF; step("R4");
        sync_in = 1'b1; step("R4");
        chk("R4 full load", 32'(dly_count), 32'hFFFF);
        sync_in = 1'b0; step("R4");
        chk("R4 full next", 32'(dly_count), 32'hFFFE);

        // R9 R6: N=1 T=1, prescale 3 on high side, 0 on low side
        pr[0] = 3; pr[1] = 0; do_reset();
        raw[0] = 1; raw[1] = 1;
        step("R9"); chk("R9 lo follows", 32'(lo_status), 1);
        step("R6"); step("R6");
        chk("R6 hi before strobe", 32'(hi_status), 0);
        step("R6");
        chk("R6 hi at 4th edge", 32'(hi_status), 1);
        raw[1] = 0; step("R9");
        chk("R9 lo follows zero", 32'(lo_status), 0);

        // R7 R8: random configurations with random runs
        for (int t = 0; t < 60; t++) begin
            for (int c = 0; c < 2; c++) begin
                int n = 1 + int'($urandom_range(31));
                if (t % 10 == 0) n = (c == 0) ? 32 : 1;
                wl[c] = CNT_W'(n);
                th[c] = CNT_W'(n / 2 + 1 + int'($urandom_range(32'(n - n / 2 - 1))));
                pr[c] = PRE_W'($urandom_range(3));
                lvl[c] = 1'b0;
            end
            do_reset();
            for (int i = 0; i < 400; i++) begin
                for (int c = 0; c < 2; c++) begin
                    if ($urandom_range(7) == 0) lvl[c] = ~lvl[c];
                    raw[c] = ($urandom_range(9) == 0) ? ~lvl[c] : lvl[c];
                end
                sync_in = ($urandom_range(15) == 0);
                dly_shadow = DLY_W'($urandom_range(40));
                step((t % 2 == 0) ? "R7" : "R8");
            end
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #400000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule